// File: doc/BRIEF.md
# Multi-Channel Compare Event Timer

This block is a memory-mapped event timer built around one free-running 64-bit main counter and a parameterised set of comparator channels. Software reaches it through a plain 32-bit register bus (byte address, write data, read data, a read strobe and a write strobe). The block answers reads one cycle after the read strobe.

Each channel watches the low 32 bits of the main counter. It can fire once (one-shot) or rearm itself by adding a stored period (periodic). A match raises an edge pulse or a sticky level on one of several interrupt lines chosen by the channel's route field, or it emits a message event made of a data word and an address word. When a global legacy-replacement bit is set, channel 0 and channel 1 drive two dedicated legacy outputs in place of their routed lines. Message requests from channels that match together are serialised through a fixed-priority port.

Top module: `evt_timer`

## Requirements
- R1: A read of offset 0x000 returns the channel count minus one in bits [4:0] and a 1 in bit 8 (legacy routing supported). A read of offset 0x004 returns the tick length in femtoseconds (parameter TICK_FS). All registers read zero after reset.
- R2: The main counter advances by one per clock only while bit 0 of the global control register (offset 0x010) is 1. Clearing that bit freezes the count.
- R3: The counter's low and high halves are written and read at offsets 0x030 and 0x034. Writing zero to both halves while stopped returns the counter to zero.
- R4: A one-shot channel fires exactly once after a comparator write, in the cycle the counter reaches the comparator. It does not fire again until the comparator is rewritten.
- R5: "Reached" means the signed 32-bit difference (counter low half minus comparator) is zero or positive. A comparator just past a 32-bit wrap waits for the wrap, and a comparator up to 2^31 behind the count fires at once.
- R6: Channel control bits are enable=0, periodic=1, set-value=2, 32-bit=3, level=4, message=5, route=[10:8]. Comparator is at channel offset +8, and channel i's base is 0x100+32*i. In periodic mode a comparator write with set-value 1 loads the comparator and clears set-value. The next write stores the period. Each match then adds the period to the comparator, and a comparator read returns the next match value.
- R7: An edge-mode channel raises irq_line_o[route] for exactly one clock, one cycle after the cycle in which the match is reached.
- R8: A level-mode channel sets its bit in the status register (offset 0x020) and holds its line high until software writes 1 to that bit. Writing 1 to other bits leaves it set.
- R9: With bit 1 of the global control register set, channel 0 drives legacy_o[0] and channel 1 drives legacy_o[1] instead of their routed line, and they send no messages.
- R10: A matching channel with message enable set drives no line. Instead it presents msg_valid_o for one clock with the data word (channel offset +0x10) and the address word (+0x14), one cycle after the match.
- R11: Messages from channels matching in the same cycle leave on consecutive cycles, lowest channel index first.
- R12: Bit 6 (message capable) and bit 7 (periodic capable) of a channel control register are read-only capability flags. Periodic and set-value writes to a channel without periodic capability, and message-enable writes to a channel without message capability, read back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| addr_i | input | 12 | Byte address of the register access |
| wdata_i | input | 32 | Write data |
| rd_i | input | 1 | Read strobe; rdata_o is valid the next cycle |
| wr_i | input | 1 | Write strobe |
| rdata_o | output | 32 | Registered read data |
| irq_line_o | output | NLINES | Routed interrupt lines |
| legacy_o | output | 2 | Legacy-replacement outputs for channels 0 and 1 |
| msg_valid_o | output | 1 | Message event strobe |
| msg_data_o | output | 32 | Message data word |
| msg_addr_o | output | 32 | Message address word |

## Verification
Two channels with message delivery enabled can reach their comparators on the same tick. The block then has two message requests in a single cycle for a port that carries only one. The bench provokes this by loading both channels with the same comparator before starting the counter. It expects the lower channel's data and address one cycle after the match and the higher channel's on the following cycle, with no routed line active at any time.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int AW = 12;

  localparam logic [AW-1:0] A_CAP  = 12'h000;
  localparam logic [AW-1:0] A_TICK = 12'h004;
  localparam logic [AW-1:0] A_GEN  = 12'h010;
  localparam logic [AW-1:0] A_STAT = 12'h020;
  localparam logic [AW-1:0] A_CLO  = 12'h030;
  localparam logic [AW-1:0] A_CHI  = 12'h034;
  localparam logic [AW-1:0] A_CH0  = 12'h100;
  localparam int CH_STRIDE = 32;

  localparam logic [4:0] O_CTL  = 5'h00;
  localparam logic [4:0] O_CMP  = 5'h08;
  localparam logic [4:0] O_MDAT = 5'h10;
  localparam logic [4:0] O_MADR = 5'h14;

  localparam int B_EN   = 0;
  localparam int B_PER  = 1;
  localparam int B_SV   = 2;
  localparam int B_W32  = 3;
  localparam int B_LVL  = 4;
  localparam int B_MSG  = 5;
  localparam int B_MCAP = 6;
  localparam int B_PCAP = 7;
  localparam int B_RT   = 8;

  typedef struct packed {
    logic [31:0] data;
    logic [31:0] addr;
  } msg_t;
endpackage

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int HW = 32
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            run_i,
  input  logic            wr_lo_i,
  input  logic            wr_hi_i,
  input  logic [HW-1:0]   wdata_i,
  output logic [2*HW-1:0] cnt_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_o <= '0;
    end else if (wr_lo_i || wr_hi_i) begin
      if (wr_lo_i) cnt_o[HW-1:0]    <= wdata_i;
      if (wr_hi_i) cnt_o[2*HW-1:HW] <= wdata_i;
    end else if (run_i) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/evt_channel.sv
module evt_channel
  import evt_pkg::*;
#(
  parameter bit PER_CAP = 1'b1,
  parameter bit MSG_CAP = 1'b1,
  parameter int RTW     = 3
) (
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic           run_i,
  input  logic [31:0]    cnt_lo_i,
  input  logic           wr_ctl_i,
  input  logic           wr_cmp_i,
  input  logic           wr_mdat_i,
  input  logic           wr_madr_i,
  input  logic [31:0]    wdata_i,
  output logic [31:0]    ctl_o,
  output logic [31:0]    cmp_o,
  output msg_t           msg_o,
  output logic           fire_o,
  output logic           lvl_o,
  output logic           per_o,
  output logic           msgen_o,
  output logic [RTW-1:0] route_o
);
  logic           en_q, per_q, sv_q, w32_q, lvl_q, msg_q, armed_q;
  logic [RTW-1:0] rt_q;
  logic [31:0]    cmp_q, prd_q, diff;

  // wraparound-safe reach test: sign of (count - comparator)
  assign diff   = cnt_lo_i - cmp_q;
  assign fire_o = en_q & armed_q & run_i & ~diff[31];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      en_q <= 1'b0; per_q <= 1'b0; sv_q <= 1'b0; w32_q <= 1'b0;
      lvl_q <= 1'b0; msg_q <= 1'b0; armed_q <= 1'b0; rt_q <= '0;
      cmp_q <= '0; prd_q <= '0; msg_o <= '0;
    end else begin
      if (wr_ctl_i) begin
        en_q  <= wdata_i[B_EN];
        per_q <= wdata_i[B_PER] & PER_CAP;
        sv_q  <= wdata_i[B_SV] & PER_CAP;
        w32_q <= wdata_i[B_W32];
        lvl_q <= wdata_i[B_LVL];
        msg_q <= wdata_i[B_MSG] & MSG_CAP;
        rt_q  <= wdata_i[B_RT +: RTW];
      end
      if (wr_cmp_i) begin
        if (per_q && !sv_q) begin
          prd_q <= wdata_i;
        end else begin
          cmp_q   <= wdata_i;
          sv_q    <= 1'b0;
          armed_q <= 1'b1;
        end
      end else if (fire_o) begin
        if (per_q) cmp_q <= cmp_q + prd_q;
        else       armed_q <= 1'b0;
      end
      if (wr_mdat_i) msg_o.data <= wdata_i;
      if (wr_madr_i) msg_o.addr <= wdata_i;
    end
  end

  always_comb begin
    ctl_o               = '0;
    ctl_o[B_EN]         = en_q;
    ctl_o[B_PER]        = per_q;
    ctl_o[B_SV]         = sv_q;
    ctl_o[B_W32]        = w32_q;
    ctl_o[B_LVL]        = lvl_q;
    ctl_o[B_MSG]        = msg_q;
    ctl_o[B_MCAP]       = MSG_CAP;
    ctl_o[B_PCAP]       = PER_CAP;
    ctl_o[B_RT +: RTW]  = rt_q;
  end

  assign cmp_o   = cmp_q;
  assign lvl_o   = lvl_q;
  assign per_o   = per_q;
  assign msgen_o = msg_q;
  assign route_o = rt_q;
endmodule

// File: rtl/evt_msg_arb.sv
module evt_msg_arb
  import evt_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic [NCH-1:0] req_i,
  input  msg_t           ch_msg_i [NCH],
  output logic [NCH-1:0] gnt_o,
  output logic           valid_o,
  output msg_t           msg_o
);
  logic [NCH-1:0] pend_q, all_req;
  msg_t           pick;

  assign all_req = pend_q | req_i;
  assign gnt_o   = all_req & (~all_req + 1'b1);

  always_comb begin
    pick = '0;
    for (int i = 0; i < NCH; i++) begin
      if (gnt_o[i]) pick = ch_msg_i[i];
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pend_q  <= '0;
      valid_o <= 1'b0;
      msg_o   <= '0;
    end else begin
      pend_q  <= all_req & ~gnt_o;
      valid_o <= |all_req;
      msg_o   <= pick;
    end
  end
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_pkg::*;
#(
  parameter int           NCH      = 3,
  parameter int           NLINES   = 8,
  parameter logic [NCH-1:0] PER_CAPS = 3'b011,
  parameter logic [NCH-1:0] MSG_CAPS = 3'b110,
  parameter logic [31:0]  TICK_FS  = 32'd41666667
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [11:0]       addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic [31:0]       rdata_o,
  output logic [NLINES-1:0] irq_line_o,
  output logic [1:0]        legacy_o,
  output logic              msg_valid_o,
  output logic [31:0]       msg_data_o,
  output logic [31:0]       msg_addr_o
);
  localparam int RTW = $clog2(NLINES);

  logic           gen_en_q, gen_leg_q;
  logic [NCH-1:0] stat_q, stat_d, stat_clr;
  logic [63:0]    cnt;
  logic           wr_lo, wr_hi, cnt_wr;
  logic [NCH-1:0] fire, lvl, per, msgen, ch_hit, wr_cmp, ovr, msg_eff, sig, msg_req, arb_gnt;
  logic [RTW-1:0] rt     [NCH];
  logic [31:0]    ch_rd  [NCH];
  msg_t           ch_msg [NCH];
  msg_t           out_msg;
  logic [31:0]    rd_d, cap_w;
  logic [NLINES-1:0] line_d;
  logic [1:0]     leg_d;

  assign wr_lo  = wr_i && (addr_i == A_CLO);
  assign wr_hi  = wr_i && (addr_i == A_CHI);
  assign cnt_wr = wr_lo | wr_hi;

  evt_counter #(.HW(32)) u_cnt (
    .clk_i(clk_i), .rst_i(rst_i), .run_i(gen_en_q),
    .wr_lo_i(wr_lo), .wr_hi_i(wr_hi), .wdata_i(wdata_i), .cnt_o(cnt)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [11:0] BASE = A_CH0 + 12'(i * CH_STRIDE);
    logic [4:0]  off;
    logic [31:0] ctl_v, cmp_v;
    assign ch_hit[i] = (addr_i[11:5] == BASE[11:5]);
    assign off       = addr_i[4:0];
    assign wr_cmp[i] = wr_i & ch_hit[i] & (off == O_CMP);
    assign ovr[i]    = gen_leg_q & (i < 2);

    evt_channel #(.PER_CAP(PER_CAPS[i]), .MSG_CAP(MSG_CAPS[i]), .RTW(RTW)) u_ch (
      .clk_i(clk_i), .rst_i(rst_i), .run_i(gen_en_q), .cnt_lo_i(cnt[31:0]),
      .wr_ctl_i(wr_i & ch_hit[i] & (off == O_CTL)),
      .wr_cmp_i(wr_cmp[i]),
      .wr_mdat_i(wr_i & ch_hit[i] & (off == O_MDAT)),
      .wr_madr_i(wr_i & ch_hit[i] & (off == O_MADR)),
      .wdata_i(wdata_i), .ctl_o(ctl_v), .cmp_o(cmp_v), .msg_o(ch_msg[i]),
      .fire_o(fire[i]), .lvl_o(lvl[i]), .per_o(per[i]), .msgen_o(msgen[i]),
      .route_o(rt[i])
    );

    always_comb begin
      case (off)
        O_CTL:   ch_rd[i] = ctl_v;
        O_CMP:   ch_rd[i] = cmp_v;
        O_MDAT:  ch_rd[i] = ch_msg[i].data;
        O_MADR:  ch_rd[i] = ch_msg[i].addr;
        default: ch_rd[i] = '0;
      endcase
    end
  end

  // status: new level matches win over a same-cycle clear
  assign stat_clr = (wr_i && addr_i == A_STAT) ? wdata_i[NCH-1:0] : '0;
  assign stat_d   = (stat_q & ~stat_clr) | (fire & lvl);
  assign msg_eff  = msgen & ~ovr;
  assign msg_req  = fire & msg_eff;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      sig[i] = ~msg_eff[i] & (lvl[i] ? stat_d[i] : fire[i]);
    end
  end

  always_comb begin
    line_d = '0;
    for (int i = 0; i < NCH; i++) begin
      if (sig[i] && !ovr[i]) line_d[rt[i]] = 1'b1;
    end
    leg_d = {ovr[1] & sig[1], ovr[0] & sig[0]};
  end

  evt_msg_arb #(.NCH(NCH)) u_arb (
    .clk_i(clk_i), .rst_i(rst_i), .req_i(msg_req), .ch_msg_i(ch_msg),
    .gnt_o(arb_gnt), .valid_o(msg_valid_o), .msg_o(out_msg)
  );
  assign msg_data_o = out_msg.data;
  assign msg_addr_o = out_msg.addr;

  always_comb begin
    cap_w      = '0;
    cap_w[4:0] = 5'(NCH - 1);
    cap_w[8]   = 1'b1;
    case (addr_i)
      A_CAP:   rd_d = cap_w;
      A_TICK:  rd_d = TICK_FS;
      A_GEN:   rd_d = {30'b0, gen_leg_q, gen_en_q};
      A_STAT:  rd_d = 32'(stat_q);
      A_CLO:   rd_d = cnt[31:0];
      A_CHI:   rd_d = cnt[63:32];
      default: rd_d = '0;
    endcase
    for (int i = 0; i < NCH; i++) begin
      if (ch_hit[i]) rd_d = ch_rd[i];
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      gen_en_q   <= 1'b0;
      gen_leg_q  <= 1'b0;
      stat_q     <= '0;
      irq_line_o <= '0;
      legacy_o   <= '0;
      rdata_o    <= '0;
    end else begin
      if (wr_i && addr_i == A_GEN) begin
        gen_en_q  <= wdata_i[0];
        gen_leg_q <= wdata_i[1];
      end
      stat_q     <= stat_d;
      irq_line_o <= line_d;
      legacy_o   <= leg_d;
      if (rd_i) rdata_o <= rd_d;
    end
  end
endmodule

// File: rtl/evt_checker.sv
module evt_checker #(
  parameter int NCH = 3
) (
  input logic           clk_i,
  input logic           rst_i,
  input logic           run_i,
  input logic           cnt_wr_i,
  input logic [63:0]    cnt_i,
  input logic [NCH-1:0] fire_i,
  input logic [NCH-1:0] per_i,
  input logic [NCH-1:0] wr_cmp_i,
  input logic [NCH-1:0] stat_i,
  input logic [NCH-1:0] clr_i,
  input logic [NCH-1:0] gnt_i
);
  // R2: stopped counter without a write holds its value
  assert_frozen_count_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(run_i) && !$past(cnt_wr_i)) |-> (cnt_i == $past(cnt_i)));

  // R4: a one-shot channel never fires two cycles in a row without a rewrite
  assert_single_shot_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (($past(fire_i) & ~$past(per_i) & ~$past(wr_cmp_i) & fire_i) == '0));

  // R8: a set status bit survives unless software cleared it
  assert_sticky_status_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (($past(stat_i) & ~$past(clr_i) & ~stat_i) == '0));

  // R11: the message port grants at most one channel per cycle
  assert_one_grant_R11: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0(gnt_i));
endmodule

bind evt_timer evt_checker #(.NCH(NCH)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .run_i(gen_en_q), .cnt_wr_i(cnt_wr),
  .cnt_i(cnt), .fire_i(fire), .per_i(per), .wr_cmp_i(wr_cmp),
  .stat_i(stat_q), .clr_i(stat_clr), .gnt_i(arb_gnt)
);

// File: tb/sim_evt_timer.sv
`timescale 1ns/1ps
module sim_evt_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [31:0] rdata;
  logic [7:0]  lines;
  logic [1:0]  leg;
  logic        mval;
  logic [31:0] mdat, madr;

  int checks = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  evt_timer u0 (
    .clk_i(clk), .rst_i(rst), .addr_i(addr), .wdata_i(wdata), .rd_i(rd), .wr_i(wr),
    .rdata_o(rdata), .irq_line_o(lines), .legacy_o(leg),
    .msg_valid_o(mval), .msg_data_o(mdat), .msg_addr_o(madr)
  );

  function automatic logic [11:0] chb(int i);
    return 12'h100 + 12'(i * 32);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(logic [11:0] a, logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rreg(logic [11:0] a, output logic [31:0] d);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic stop_zero();
    wreg(12'h010, 32'h0);
    wreg(12'h030, 32'h0);
    wreg(12'h034, 32'h0);
  endtask

  task automatic idle_all();
    for (int i = 0; i < 3; i++) wreg(chb(i), 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1: identity and reset state
    rreg(12'h000, v); chk("R1 cap", v, 32'h0000_0102);
    rreg(12'h004, v); chk("R1 tick", v, 32'd41666667);
    rreg(12'h010, v); chk("R1 gen reset", v, 32'h0);
    rreg(12'h030, v); chk("R2 counter idle after reset", v, 32'h0);
    chk("R1 lines reset", {22'b0, mval, leg, lines}, 32'h0);

    // R3 / R2: halves writable, count runs and freezes
    wreg(12'h030, 32'h0000_1234);
    wreg(12'h034, 32'h0000_ABCD);
    rreg(12'h030, v); chk("R3 low half", v, 32'h0000_1234);
    rreg(12'h034, v); chk("R3 high half", v, 32'h0000_ABCD);
    wreg(12'h010, 32'h1);
    repeat (9) @(negedge clk);
    wreg(12'h010, 32'h0);
    rreg(12'h030, v); chk("R2 counted ticks", v, 32'h0000_1234 + 32'd10);
    repeat (7) @(negedge clk);
    rreg(12'h030, v); chk("R2 frozen", v, 32'h0000_1234 + 32'd10);
    stop_zero();
    rreg(12'h030, v); chk("R3 zero low", v, 32'h0);
    rreg(12'h034, v); chk("R3 zero high", v, 32'h0);

    // R4 / R7: one-shot edge on line 3 at compare 20
    wreg(chb(1), 32'h0000_0301);
    wreg(chb(1) + 12'h8, 32'd20);
    wreg(12'h010, 32'h1);
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      chk("R4 R7 oneshot edge line3", 32'(lines[3]), 32'(k == 21));
    end
    stop_zero();

    // R5: comparator beyond the 32-bit wrap
    wreg(12'h030, 32'hFFFF_FFF0);
    wreg(chb(1) + 12'h8, 32'd5);
    wreg(12'h010, 32'h1);
    for (int k = 1; k <= 24; k++) begin
      @(negedge clk);
      chk("R5 wrap wait", 32'(lines[3]), 32'(k == 22));
    end
    stop_zero();
    // R5: comparator behind the count fires at once
    wreg(12'h030, 32'd100);
    wreg(chb(1) + 12'h8, 32'd90);
    wreg(12'h010, 32'h1);
    @(negedge clk); chk("R5 behind fires", 32'(lines[3]), 32'h1);
    @(negedge clk); chk("R5 behind single pulse", 32'(lines[3]), 32'h0);
    stop_zero();
    idle_all();

    // R6: periodic via set-value on channel 0, line 2
    wreg(chb(0), 32'h0000_0207);
    wreg(chb(0) + 12'h8, 32'd10);
    rreg(chb(0), v); chk("R6 set-value self-clears", v, 32'h0000_0283);
    wreg(chb(0) + 12'h8, 32'd7);
    rreg(chb(0) + 12'h8, v); chk("R6 second write keeps comparator", v, 32'd10);
    wreg(12'h010, 32'h1);
    for (int k = 1; k <= 30; k++) begin
      @(negedge clk);
      chk("R6 periodic line2", 32'(lines[2]), 32'(k == 11 || k == 18 || k == 25));
    end
    wreg(12'h010, 32'h0);
    rreg(chb(0) + 12'h8, v); chk("R6 next match value", v, 32'd31);
    stop_zero();
    idle_all();

    // R8: level on channel 1, line 5, W1C
    wreg(chb(1), 32'h0000_0511);
    wreg(chb(1) + 12'h8, 32'd6);
    wreg(12'h010, 32'h1);
    for (int k = 1; k <= 15; k++) begin
      @(negedge clk);
      chk("R8 level held", 32'(lines[5]), 32'(k >= 7));
    end
    rreg(12'h020, v); chk("R8 status set", v, 32'h2);
    wreg(12'h020, 32'h1);
    rreg(12'h020, v); chk("R8 other bit clear ignored", v, 32'h2);
    chk("R8 line still high", 32'(lines[5]), 32'h1);
    wreg(12'h020, 32'h2);
    chk("R8 line dropped", 32'(lines[5]), 32'h0);
    rreg(12'h020, v); chk("R8 status cleared", v, 32'h0);
    stop_zero();
    idle_all();

    // R9: legacy replacement of channels 0 and 1
    wreg(chb(0), 32'h0000_0401);
    wreg(chb(0) + 12'h8, 32'd5);
    wreg(chb(1), 32'h0000_0401);
    wreg(chb(1) + 12'h8, 32'd9);
    wreg(12'h010, 32'h3);
    for (int k = 1; k <= 14; k++) begin
      @(negedge clk);
      chk("R9 legacy outputs", {29'b0, lines[4], leg}, {29'b0, 1'b0, 1'(k == 10), 1'(k == 6)});
    end
    stop_zero();
    idle_all();

    // R12: capability masking
    wreg(chb(0), 32'h0000_0021);
    rreg(chb(0), v); chk("R12 no message cap", v, 32'h0000_0081);
    wreg(chb(2), 32'h0000_0007);
    rreg(chb(2), v); chk("R12 no periodic cap", v, 32'h0000_0041);
    idle_all();

    // R10 / R11: two message channels matching together
    wreg(chb(1) + 12'h10, 32'h1111_0001);
    wreg(chb(1) + 12'h14, 32'hFEE0_1000);
    wreg(chb(2) + 12'h10, 32'h2222_0002);
    wreg(chb(2) + 12'h14, 32'hFEE0_2000);
    wreg(chb(1), 32'h0000_0621);
    wreg(chb(2), 32'h0000_0621);
    wreg(chb(1) + 12'h8, 32'd8);
    wreg(chb(2) + 12'h8, 32'd8);
    wreg(12'h010, 32'h1);
    for (int k = 1; k <= 14; k++) begin
      @(negedge clk);
      chk("R10 no line for message", 32'(lines[6]), 32'h0);
      chk("R11 message strobe", 32'(mval), 32'(k == 9 || k == 10));
      if (k == 9) begin
        chk("R11 first data ch1", mdat, 32'h1111_0001);
        chk("R10 first addr ch1", madr, 32'hFEE0_1000);
      end
      if (k == 10) begin
        chk("R11 second data ch2", mdat, 32'h2222_0002);
        chk("R10 second addr ch2", madr, 32'hFEE0_2000);
      end
    end
    stop_zero();
    idle_all();

    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule